// File: doc/BRIEF.md
# Transmit FIFO with Retransmit Flush

This block buffers outgoing bytes between a host and a serial transmitter. The host places a byte on a parallel data bus and pulses an active-low write strobe. The byte is stored when the strobe rises. A ready output tells the host whether another byte fits. Ready drops as soon as the strobe of the write that will fill the last free slot goes low, so the host never sees room that is already claimed. On the other side, the serializer pops bytes in order from a show-ahead read port. It reports transmit underflow and collision events on two inputs.

Either event starts a retransmit pulse of fixed length. For the whole pulse, the buffer is emptied and ready is held low. The transmit path then restarts from a clean buffer. Reset behaves like a held retransmit: the retransmit output is high and ready is low. Ready comes back on the first clock after reset is released.

The write strobe is asynchronous to the block clock. It passes through a synchronizer, and both of its edges are detected in the clock domain. A write attempted while ready is low is dropped and leaves a sticky overflow indication.

Top module: `txFifoFlush`

## Requirements
- R1: `txReady` is high exactly when the stored bytes plus any write already started number fewer than DEPTH and no retransmit pulse is active. During reset `txReady` is 0 and `retxPulse` is 1. On the first clock edge after `rstN` goes high, `retxPulse` falls and `txReady` rises.
- R2: `hostData` is stored on the rising edge of the active-low `hostWrN`. This edge is registered on the third clock edge after the pin goes high (two synchronizer stages plus edge detection). Bytes leave in write order, and `popData` shows the oldest stored byte whenever `txEmpty` is 0.
- R3: The falling edge of the write strobe that claims the last free slot drives `txReady` low on the third clock edge after the pin falls. This happens while the byte is not yet stored.
- R4: A falling write strobe seen while `txReady` is 0 stores nothing and sets `overflow`. `overflow` stays 1 until reset.
- R5: `underflowIn` or `collisionIn` high at a clock edge makes `retxPulse` high from that edge for exactly PULSE_CYCLES clock cycles (default 80, which is 800 ns at 100 MHz).
- R6: An underflow or collision that arrives while the pulse is active restarts the full PULSE_CYCLES width from that edge.
- R7: While `retxPulse` is high, the buffer is empty (`txEmpty` is 1), pops do nothing and `txReady` is 0. Bytes stored before the event are discarded.
- R8: When a retransmit event falls on the same clock edge as a write commit, the flush wins and the byte is discarded.
- R9: A pop and a write commit on the same clock edge both take effect, and the number of stored bytes stays the same.
- R10: `popReq` while `txEmpty` is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostData | input | DATA_W | Byte from the host |
| hostWrN | input | 1 | Host write strobe, active low, asynchronous |
| txReady | output | 1 | At least one free slot and no retransmit |
| overflow | output | 1 | Sticky: a write was attempted while not ready |
| popReq | input | 1 | Serializer takes the head byte |
| popData | output | DATA_W | Head byte (show-ahead) |
| txEmpty | output | 1 | No byte stored |
| underflowIn | input | 1 | Serializer ran out of data mid-frame |
| collisionIn | input | 1 | Serializer detected a collision |
| retxPulse | output | 1 | Retransmit pulse; buffer flushed while high |

## Verification
A retransmit event can land on the same clock edge as the commit of a host write. The bench provokes this by raising `collisionIn` exactly at the third edge after the strobe returns high. The flush must win: the buffer is empty through the pulse and afterwards, and the byte is never popped.

A pop and a commit can also share an edge. The bench aligns `popReq` with a commit and then checks that the older byte left, the new byte remains, and the count is unchanged.

A behavioural queue model predicts every output on every clock, so any slip of one cycle in either collision shows up at once.

// File: rtl/txf_pkg.sv
package txf_pkg;

  // Strobes the control side issues to the storage side each cycle.
  typedef struct packed {
    logic push;   // commit the held host byte
    logic pop;    // drop the head byte
    logic flush;  // empty the buffer
  } txfStrobes_t;

endpackage

// File: rtl/txfDatapath.sv
module txfDatapath
  import txf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  txfStrobes_t                    strobes,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              rdData,
  output logic [$clog2(DEPTH+1)-1:0]     occupancy,
  output logic                           empty
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam bit IS_POW2 = (DEPTH == (1 << PTR_W));

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrPtrNext, rdPtrNext;

  // Pointer wrap: free rollover for power-of-two depths, compare otherwise.
  generate
    if (IS_POW2) begin : g_wrap_pow2
      assign wrPtrNext = wrPtr + PTR_W'(1);
      assign rdPtrNext = rdPtr + PTR_W'(1);
    end else begin : g_wrap_cmp
      assign wrPtrNext = (wrPtr == LAST_PTR) ? '0 : wrPtr + PTR_W'(1);
      assign rdPtrNext = (rdPtr == LAST_PTR) ? '0 : rdPtr + PTR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.push) begin
      mem[wrPtr] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else if (strobes.flush) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      occupancy <= '0;
    end else begin
      if (strobes.push) wrPtr <= wrPtrNext;
      if (strobes.pop)  rdPtr <= rdPtrNext;
      case ({strobes.push, strobes.pop})
        2'b10:   occupancy <= occupancy + CNT_W'(1);
        2'b01:   occupancy <= occupancy - CNT_W'(1);
        default: occupancy <= occupancy;
      endcase
    end
  end

  assign rdData = mem[rdPtr];
  assign empty  = (occupancy == '0);

endmodule

// File: rtl/txfControl.sv
module txfControl
  import txf_pkg::*;
#(
  parameter int DEPTH        = 8,
  parameter int PULSE_CYCLES = 80,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           hostWrN,
  input  logic                           popReq,
  input  logic                           underflowIn,
  input  logic                           collisionIn,
  input  logic [$clog2(DEPTH+1)-1:0]     occupancy,
  input  logic                           fifoEmpty,
  output txfStrobes_t                    strobes,
  output logic                           txReady,
  output logic                           retxPulse,
  output logic                           overflow
);

  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int RES_W  = CNT_W + 1;
  localparam logic [RES_W-1:0] DEPTH_V = RES_W'(DEPTH);
  localparam int PCNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
  localparam logic [PCNT_W-1:0] PULSE_LAST = PCNT_W'(PULSE_CYCLES - 1);

  // Strobe synchronizer and edge detector
  logic [SYNC_STAGES-1:0] wrSync;
  logic                   wrPrev;
  logic                   wrLevel, fallEdge, riseEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrSync <= '1;
      wrPrev <= 1'b1;
    end else begin
      wrSync <= {wrSync[SYNC_STAGES-2:0], hostWrN};
      wrPrev <= wrLevel;
    end
  end

  assign wrLevel  = wrSync[SYNC_STAGES-1];
  assign fallEdge = wrPrev & ~wrLevel;
  assign riseEdge = ~wrPrev & wrLevel;

  // Retransmit timer
  logic              retxActive;
  logic [PCNT_W-1:0] pulseCnt;
  logic              retxEvent, flushNow;

  assign retxEvent = underflowIn | collisionIn;
  assign flushNow  = retxActive | retxEvent;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retxActive <= 1'b1;
      pulseCnt   <= '0;
    end else if (retxEvent) begin
      retxActive <= 1'b1;
      pulseCnt   <= PULSE_LAST;
    end else if (retxActive) begin
      if (pulseCnt == '0) retxActive <= 1'b0;
      else                pulseCnt   <= pulseCnt - PCNT_W'(1);
    end
  end

  // Slot reservation: a started write holds a slot until it commits
  logic             armed;
  logic [RES_W-1:0] reserved;
  logic             readyInt;

  assign reserved = {1'b0, occupancy} + {{CNT_W{1'b0}}, armed};
  assign readyInt = ~retxActive & (reserved < DEPTH_V);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (flushNow)                  armed <= 1'b0;
      else if (fallEdge && readyInt) armed <= 1'b1;
      else if (riseEdge)             armed <= 1'b0;
      if (fallEdge && !readyInt)     overflow <= 1'b1;
    end
  end

  always_comb begin
    strobes.flush = flushNow;
    strobes.push  = riseEdge & armed & ~flushNow;
    strobes.pop   = popReq & ~fifoEmpty & ~flushNow;
  end

  assign txReady   = readyInt;
  assign retxPulse = retxActive;

endmodule

// File: rtl/txFifoFlush.sv
module txFifoFlush
  import txf_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int DEPTH        = 8,
  parameter int PULSE_CYCLES = 80
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostWrN,
  output logic              txReady,
  output logic              overflow,
  input  logic              popReq,
  output logic [DATA_W-1:0] popData,
  output logic              txEmpty,
  input  logic              underflowIn,
  input  logic              collisionIn,
  output logic              retxPulse
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  txfStrobes_t      strobes;
  logic [CNT_W-1:0] occupancy;

  txfControl #(
    .DEPTH        (DEPTH),
    .PULSE_CYCLES (PULSE_CYCLES),
    .SYNC_STAGES  (2)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .hostWrN     (hostWrN),
    .popReq      (popReq),
    .underflowIn (underflowIn),
    .collisionIn (collisionIn),
    .occupancy   (occupancy),
    .fifoEmpty   (txEmpty),
    .strobes     (strobes),
    .txReady     (txReady),
    .retxPulse   (retxPulse),
    .overflow    (overflow)
  );

  txfDatapath #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (hostData),
    .rdData    (popData),
    .occupancy (occupancy),
    .empty     (txEmpty)
  );

endmodule

// File: rtl/txFifoFlushChecker.sv
module txFifoFlushChecker #(
  parameter int PULSE_CYCLES = 80
) (
  input logic clk,
  input logic rstN,
  input logic txReady,
  input logic overflow,
  input logic txEmpty,
  input logic underflowIn,
  input logic collisionIn,
  input logic retxPulse
);

  // Cycles of pulse seen since the most recent event (0 = none counted).
  int widthCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          widthCnt <= 0;
    else if (underflowIn || collisionIn) widthCnt <= 1;
    else if (retxPulse)                 widthCnt <= widthCnt + 1;
    else                                widthCnt <= 0;
  end

  assert_ready_blocked_R1: assert property (@(posedge clk) disable iff (!rstN)
    retxPulse |-> !txReady);

  assert_overflow_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_event_raises_retx_R5: assert property (@(posedge clk) disable iff (!rstN)
    (underflowIn || collisionIn) |=> retxPulse);

  assert_width_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (retxPulse && widthCnt != 0 && widthCnt < PULSE_CYCLES) |=> retxPulse);

  assert_width_max_R5: assert property (@(posedge clk) disable iff (!rstN)
    (retxPulse && widthCnt != 0) |-> (widthCnt <= PULSE_CYCLES));

  assert_flush_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    retxPulse |-> txEmpty);

endmodule

bind txFifoFlush txFifoFlushChecker #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .txReady     (txReady),
  .overflow    (overflow),
  .txEmpty     (txEmpty),
  .underflowIn (underflowIn),
  .collisionIn (collisionIn),
  .retxPulse   (retxPulse)
);

// File: tb/txFifoFlush_tb.sv
`timescale 1ns/1ps
module txFifoFlush_tb;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 8;
  localparam int PULSE  = 80;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [DATA_W-1:0] hostData = '0;
  logic              hostWrN = 1'b1;
  logic              popReq = 1'b0;
  logic              underflowIn = 1'b0;
  logic              collisionIn = 1'b0;
  logic              txReady, overflow, txEmpty, retxPulse;
  logic [DATA_W-1:0] popData;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  txFifoFlush #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PULSE_CYCLES(PULSE)) u_dut (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostWrN(hostWrN),
    .txReady(txReady), .overflow(overflow), .popReq(popReq), .popData(popData),
    .txEmpty(txEmpty), .underflowIn(underflowIn), .collisionIn(collisionIn),
    .retxPulse(retxPulse)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [DATA_W-1:0] q[$];
  bit mArmed = 0, mS1 = 1, mS2 = 1, mS3 = 1, mActive = 1, mOvf = 0;
  int mCnt = 0;

  always @(posedge clk) begin
    bit fall, rise, evt, flush, rdy;
    cycles++;
    if (!rstN) begin
      q.delete(); mArmed = 0; mS1 = 1; mS2 = 1; mS3 = 1;
      mActive = 1; mCnt = 0; mOvf = 0;
    end else begin
      fall  = mS3 && !mS2;
      rise  = !mS3 && mS2;
      evt   = underflowIn || collisionIn;
      flush = mActive || evt;
      rdy   = !mActive && (q.size() + int'(mArmed) < DEPTH);
      if (fall && !rdy) mOvf = 1;
      if (flush) q.delete();
      else begin
        if (popReq && q.size() > 0) void'(q.pop_front());
        if (rise && mArmed) q.push_back(hostData);
      end
      if (flush) mArmed = 0;
      else if (fall && rdy) mArmed = 1;
      else if (rise) mArmed = 0;
      if (evt) begin mActive = 1; mCnt = PULSE - 1; end
      else if (mActive) begin
        if (mCnt == 0) mActive = 0; else mCnt--;
      end
      mS3 = mS2; mS2 = mS1; mS1 = hostWrN;
    end
  end

  always @(negedge clk) begin
    if (cycles > 0 && !finished) begin
      check("R1 txReady vs model", txReady, (!mActive && (q.size() + int'(mArmed) < DEPTH)));
      check("R5 retxPulse vs model", retxPulse, mActive);
      check("R7 txEmpty vs model", txEmpty, (q.size() == 0));
      check("R4 overflow vs model", overflow, mOvf);
      if (q.size() > 0) check("R2 popData vs model", popData, q[0]);
    end
  end

  task automatic hostWrite(input logic [7:0] d, input bit popAtCommit, input bit colAtCommit);
    @(negedge clk); hostData = d; hostWrN = 1'b0;
    repeat (4) @(negedge clk);
    hostWrN = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); popReq = popAtCommit; collisionIn = colAtCommit;
    @(negedge clk); popReq = 1'b0; collisionIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic popExpect(input logic [7:0] exp, input string tag);
    @(negedge clk);
    check(tag, popData, exp);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
  endtask

  task automatic measurePulse(output int n);
    n = 0;
    while (retxPulse === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 ready low in reset", txReady, 0);
    check("R1 retx high in reset", retxPulse, 1);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 ready after release", txReady, 1);
    check("R1 retx low after release", retxPulse, 0);

    // R2: order of delivery
    hostWrite(8'h11, 0, 0); hostWrite(8'h22, 0, 0); hostWrite(8'h33, 0, 0);
    popExpect(8'h11, "R2 first byte");
    popExpect(8'h22, "R2 second byte");
    popExpect(8'h33, "R2 third byte");
    @(negedge clk); check("R2 empty after drain", txEmpty, 1);

    // R10: pop on empty
    popReq = 1'b1; repeat (3) @(negedge clk); popReq = 1'b0;
    check("R10 still empty", txEmpty, 1);
    hostWrite(8'h44, 0, 0);
    popExpect(8'h44, "R10 next byte intact");

    // R9: pop and commit on the same edge
    hostWrite(8'h55, 0, 0);
    hostWrite(8'h66, 1, 0);
    check("R9 one byte remains", txEmpty, 0);
    popExpect(8'h66, "R9 newer byte kept");
    @(negedge clk); check("R9 empty after", txEmpty, 1);

    // R3: last slot claimed at the falling edge
    for (int i = 1; i <= DEPTH - 1; i++) hostWrite(8'(i), 0, 0);
    check("R1 ready with one slot free", txReady, 1);
    @(negedge clk); hostData = 8'(DEPTH); hostWrN = 1'b0;
    repeat (4) @(negedge clk);
    check("R3 ready low before commit", txReady, 0);
    hostWrN = 1'b1;
    repeat (5) @(negedge clk);
    check("R3 ready low when full", txReady, 0);

    // R4: write while not ready
    hostWrite(8'hEE, 0, 0);
    check("R4 overflow set", overflow, 1);
    popExpect(8'h01, "R4 stored data unchanged");
    @(negedge clk);
    check("R1 ready after pop", txReady, 1);
    check("R4 overflow sticky", overflow, 1);
    for (int i = 2; i <= DEPTH; i++) popExpect(8'(i), "R4 no extra byte");
    @(negedge clk); check("R4 dropped byte absent", txEmpty, 1);

    // R5/R7: collision flushes and times the pulse
    hostWrite(8'hA1, 0, 0); hostWrite(8'hA2, 0, 0);
    @(negedge clk); collisionIn = 1'b1;
    @(negedge clk); collisionIn = 1'b0;
    check("R7 flushed at pulse start", txEmpty, 1);
    check("R7 ready low in pulse", txReady, 0);
    measurePulse(n);
    check("R5 collision pulse width", n, PULSE);
    check("R7 ready after pulse", txReady, 1);
    check("R7 empty after pulse", txEmpty, 1);

    // R5 underflow, R6 restart, R7 pops ignored
    @(negedge clk); underflowIn = 1'b1;
    @(negedge clk); underflowIn = 1'b0; popReq = 1'b1;
    repeat (28) @(negedge clk);
    popReq = 1'b0;
    check("R5 underflow pulse active", retxPulse, 1);
    collisionIn = 1'b1;
    @(negedge clk); collisionIn = 1'b0;
    measurePulse(n);
    check("R6 restarted width", n, PULSE);

    // R8: event on the commit edge
    hostWrite(8'h5A, 0, 1);
    while (retxPulse === 1'b1) @(negedge clk);
    check("R8 byte discarded", txEmpty, 1);
    check("R8 ready after pulse", txReady, 1);

    finishRun();
  end

endmodule